// File: doc/BRIEF.md
# Shared-Pin Bus Demultiplexer with Page Retention

This block sits between a microcontroller whose 8-bit data shares pins with one byte of the address and a memory or peripheral array that needs a steady 17-bit address and separate strobes. It brings every bus pin into its own clock domain. It catches the time-shared address byte on the falling edge of the address latch enable. From that byte it rebuilds the full address. In page organisations the byte is the upper address byte, and it stays in place through page-hit cycles that have no latch pulse.

A two-bit mode input selects one of four bus organisations. The organisations differ in which address byte is time-shared and in whether program and data reads use separate strobes or one. The block decodes a read, a program-fetch flag, a write and a read/write clash. It also gives two independent chip selects: a narrow one covering the two boot configuration bytes, and a wide one over the low code space.

Top module: `mux_bus_demux`

## Requirements
- R1: After reset the latched byte is 00h and no strobe output is active. A page-organisation access before any latch pulse therefore decodes to page 00h.
- R2: In modes 0 and 1 (non-page), `addr[7:0]` is the value that `ad` held in the last sample with `ale` high before its falling edge, and `addr[15:8]` follows `adr_fixed`.
- R3: In modes 2 and 3 (page), `addr[15:8]` is the byte latched from `ad` at the falling edge of `ale`, and `addr[7:0]` follows `adr_fixed`.
- R4: Without a new `ale` falling edge, the latched byte is kept while `adr_fixed` changes (page hit).
- R5: Changes on `ad` while `ale` is low have no effect on `addr`.
- R6: `addr[16]` follows the `a16` pin in every mode.
- R7: In split modes 0 and 3, `ctl1_n` low gives `rd_en`=1 with `psen_rd`=0, and `ctl2_n` low gives `rd_en`=1 with `psen_rd`=1.
- R8: In single-read modes 1 and 2, `ctl1_n` low gives `rd_en`=1 and `psen_rd`=1, and `ctl2_n` is ignored.
- R9: `wr_n` low gives `wr_en`=1 in every mode.
- R10: When a read and a write are requested together, `rd_en`, `psen_rd` and `wr_en` are 0 and `conflict` is 1.
- R11: `cfg_cs` is 1 exactly when `addr` is 0FFF8h or 0FFF9h.
- R12: `pri_cs` is 1 exactly when `addr` lies in 00000h to 07FFFh. It is decoded independently of `cfg_cs`.
- R13: A change of `mode_sel` takes effect only at a clock edge where `wr_n`, `ctl1_n` and `ctl2_n` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Bus organisation 0..3 |
| ale | input | 1 | Address latch enable, falling edge captures `ad` |
| ad | input | 8 | Shared address/data pins |
| adr_fixed | input | 8 | Dedicated address byte pins |
| a16 | input | 1 | Extended address bit |
| wr_n | input | 1 | Write strobe, active low |
| ctl1_n | input | 1 | First read control input, active low |
| ctl2_n | input | 1 | Second read control input, active low |
| addr | output | 17 | Rebuilt address |
| rd_en | output | 1 | Read active |
| psen_rd | output | 1 | Active read is a program fetch |
| wr_en | output | 1 | Write active |
| conflict | output | 1 | Read and write requested together |
| cfg_cs | output | 1 | Configuration-byte chip select |
| pri_cs | output | 1 | Low code-space chip select |

## Verification
A corrupted latched byte appears at once on the upper address byte in page modes, or on the lower byte in non-page modes. It persists until the next latch pulse, so the bench checks the address after every page hit and after every data-phase change on the shared pins. A mode register that is wrong or updated too early shows on the next strobe as a swapped program-fetch flag or as a read that appears from the ignored input. Pins reach the outputs two clock edges after they change and the latched byte three edges after `ale` falls, so every check samples four edges after stimulus.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W + 1;

  typedef enum logic [1:0] {
    BUS_NP_SPLIT  = 2'd0,
    BUS_NP_SINGLE = 2'd1,
    BUS_PG_SINGLE = 2'd2,
    BUS_PG_SPLIT  = 2'd3
  } bus_mode_e;

  // Page organisations time-share the upper address byte.
  function automatic logic mode_is_page(input logic [1:0] m);
    return m[1];
  endfunction

  // Single-read organisations carry every read on the first control input.
  function automatic logic mode_is_single(input logic [1:0] m);
    return (m == BUS_NP_SINGLE) || (m == BUS_PG_SINGLE);
  endfunction

  function automatic logic [ADDR_W-1:0] build_addr(
    input logic              page,
    input logic              ext,
    input logic [BYTE_W-1:0] latched,
    input logic [BYTE_W-1:0] fixed
  );
    return page ? {ext, latched, fixed} : {ext, fixed, latched};
  endfunction

  function automatic logic in_window(
    input logic [ADDR_W-1:0] a,
    input logic [ADDR_W-1:0] base,
    input logic [ADDR_W-1:0] mask
  );
    return (a & mask) == base;
  endfunction

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] r;
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= g_stage[g-1].r;
      end
    end
  end

  assign q = g_stage[STAGES-1].r;

  initial begin
    assert (STAGES >= 2) else $error("sync_chain needs at least two stages");
  end

endmodule

// File: rtl/ale_latch.sv
module ale_latch #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale_s,
  input  logic [BW-1:0] byte_s,
  output logic [BW-1:0] lat_q,
  output logic          ale_fall
);

  logic          ale_d;
  logic [BW-1:0] byte_d;

  // One extra stage keeps the byte seen while ALE was still high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_d  <= 1'b0;
      byte_d <= '0;
    end else begin
      ale_d  <= ale_s;
      byte_d <= byte_s;
    end
  end

  assign ale_fall = ale_d & ~ale_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lat_q <= '0;
    else if (ale_fall) lat_q <= byte_d;
  end

  p_fall_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ale_fall |=> !ale_fall);

  p_hold_no_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_fall |=> $stable(lat_q));

  p_load_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale_fall |=> (lat_q == $past(byte_d)));

endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
  import mux_bus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       wr_s_n,
  input  logic       c1_s_n,
  input  logic       c2_s_n,
  output logic [1:0] mode_q,
  output logic       busy,
  output logic       rd_en,
  output logic       psen_rd,
  output logic       wr_en,
  output logic       conflict
);

  logic single;
  logic rd_raw, psen_raw, wr_raw;

  assign busy = ~wr_s_n | ~c1_s_n | ~c2_s_n;

  // Mode is only taken between bus cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= BUS_NP_SPLIT;
    else if (!busy) mode_q <= mode_sel;
  end

  assign single   = mode_is_single(mode_q);
  assign rd_raw   = ~c1_s_n | (~single & ~c2_s_n);
  assign psen_raw = single ? ~c1_s_n : ~c2_s_n;
  assign wr_raw   = ~wr_s_n;

  assign conflict = rd_raw & wr_raw;
  assign rd_en    = rd_raw   & ~conflict;
  assign psen_rd  = psen_raw & ~conflict;
  assign wr_en    = wr_raw   & ~conflict;

  p_rd_wr_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

  p_conflict_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> (!rd_en && !wr_en && !psen_rd));

  p_psen_is_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    psen_rd |-> rd_en);

  p_mode_frozen_r13: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q));

endmodule

// File: rtl/addr_decode.sv
module addr_decode
  import mux_bus_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CFG_BASE = 17'h0FFF8,
  parameter logic [ADDR_W-1:0] CFG_MASK = 17'h1FFFE,
  parameter logic [ADDR_W-1:0] PRI_BASE = 17'h00000,
  parameter logic [ADDR_W-1:0] PRI_MASK = 17'h18000
) (
  input  logic [1:0]        mode_q,
  input  logic              ext_s,
  input  logic [BYTE_W-1:0] lat_q,
  input  logic [BYTE_W-1:0] fixed_s,
  output logic [ADDR_W-1:0] addr,
  output logic              cfg_cs,
  output logic              pri_cs
);

  assign addr   = build_addr(mode_is_page(mode_q), ext_s, lat_q, fixed_s);
  assign cfg_cs = in_window(addr, CFG_BASE, CFG_MASK);
  assign pri_cs = in_window(addr, PRI_BASE, PRI_MASK);

endmodule

// File: rtl/mux_bus_demux.sv
module mux_bus_demux
  import mux_bus_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CFG_BASE    = 17'h0FFF8,
  parameter logic [ADDR_W-1:0] CFG_MASK    = 17'h1FFFE,
  parameter logic [ADDR_W-1:0] PRI_BASE    = 17'h00000,
  parameter logic [ADDR_W-1:0] PRI_MASK    = 17'h18000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              ale,
  input  logic [BYTE_W-1:0] ad,
  input  logic [BYTE_W-1:0] adr_fixed,
  input  logic              a16,
  input  logic              wr_n,
  input  logic              ctl1_n,
  input  logic              ctl2_n,
  output logic [ADDR_W-1:0] addr,
  output logic              rd_en,
  output logic              psen_rd,
  output logic              wr_en,
  output logic              conflict,
  output logic              cfg_cs,
  output logic              pri_cs
);

  localparam int DATA_W = 2 * BYTE_W + 2;

  logic [DATA_W-1:0] data_s;
  logic [2:0]        strb_s;
  logic              ale_s, ext_s;
  logic [BYTE_W-1:0] ad_s, fixed_s, lat_q;
  logic              ale_fall, busy;
  logic [1:0]        mode_q;

  sync_chain #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_data (
    .clk(clk), .rst_n(rst_n),
    .d({ale, a16, ad, adr_fixed}),
    .q(data_s)
  );

  sync_chain #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync_strb (
    .clk(clk), .rst_n(rst_n),
    .d({wr_n, ctl1_n, ctl2_n}),
    .q(strb_s)
  );

  assign {ale_s, ext_s, ad_s, fixed_s} = data_s;

  ale_latch #(.BW(BYTE_W)) u_latch (
    .clk(clk), .rst_n(rst_n),
    .ale_s(ale_s), .byte_s(ad_s),
    .lat_q(lat_q), .ale_fall(ale_fall)
  );

  strobe_decode u_strobe (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .wr_s_n(strb_s[2]), .c1_s_n(strb_s[1]), .c2_s_n(strb_s[0]),
    .mode_q(mode_q), .busy(busy),
    .rd_en(rd_en), .psen_rd(psen_rd), .wr_en(wr_en), .conflict(conflict)
  );

  addr_decode #(
    .CFG_BASE(CFG_BASE), .CFG_MASK(CFG_MASK),
    .PRI_BASE(PRI_BASE), .PRI_MASK(PRI_MASK)
  ) u_addr (
    .mode_q(mode_q), .ext_s(ext_s), .lat_q(lat_q), .fixed_s(fixed_s),
    .addr(addr), .cfg_cs(cfg_cs), .pri_cs(pri_cs)
  );

  p_cs_disjoint_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_cs |-> !pri_cs);

  p_cfg_low_space_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_cs |-> !addr[ADDR_W-1]);

  p_fall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale_fall && !busy && $stable(mode_q)) |=> $stable(lat_q));

endmodule

// File: tb/tb_mux_bus_demux.sv
module tb_mux_bus_demux;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'd3;
  logic        ale = 1'b0;
  logic [7:0]  ad = 8'h00;
  logic [7:0]  adr_fixed = 8'h5A;
  logic        a16 = 1'b0;
  logic        wr_n = 1'b1, ctl1_n = 1'b1, ctl2_n = 1'b1;
  logic [16:0] addr;
  logic        rd_en, psen_rd, wr_en, conflict, cfg_cs, pri_cs;

  int tests = 0;
  int fails = 0;
  logic [7:0] lat_exp = 8'h00;
  logic [1:0] cur_mode = 2'd3;

  always #4 clk = ~clk;

  mux_bus_demux dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ale(ale), .ad(ad),
    .adr_fixed(adr_fixed), .a16(a16), .wr_n(wr_n), .ctl1_n(ctl1_n),
    .ctl2_n(ctl2_n), .addr(addr), .rd_en(rd_en), .psen_rd(psen_rd),
    .wr_en(wr_en), .conflict(conflict), .cfg_cs(cfg_cs), .pri_cs(pri_cs)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [16:0] exp_addr(input logic [1:0] m, input logic x,
                                           input logic [7:0] l, input logic [7:0] f);
    logic [16:0] v;
    if (m >= 2) v = 17'(x) * 17'h10000 + 17'(l) * 17'h100 + 17'(f);
    else        v = 17'(x) * 17'h10000 + 17'(f) * 17'h100 + 17'(l);
    return v;
  endfunction

  task automatic check_addr(input string req);
    logic [16:0] e;
    e = exp_addr(cur_mode, a16, lat_exp, adr_fixed);
    check(addr == e, req, 32'(addr), 32'(e));
    check(cfg_cs == (e == 17'h0FFF8 || e == 17'h0FFF9), "R11", 32'(cfg_cs), 32'(e));
    check(pri_cs == (e < 17'h08000), "R12", 32'(pri_cs), 32'(e));
  endtask

  task automatic ale_cycle(input logic [7:0] b);
    @(negedge clk);
    ad = b; ale = 1'b1;
    repeat (3) @(negedge clk);
    ale = 1'b0;
    repeat (3) @(negedge clk);
    ad = ~b;
    lat_exp = b;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode_sel = m; cur_mode = m;
    settle();
  endtask

  task automatic strobe(input logic w, input logic c1, input logic c2,
                        input logic er, input logic ep, input logic ew, input logic ec,
                        input string req);
    @(negedge clk);
    wr_n = w; ctl1_n = c1; ctl2_n = c2;
    settle();
    check({rd_en, psen_rd, wr_en, conflict} == {er, ep, ew, ec}, req,
          32'({rd_en, psen_rd, wr_en, conflict}), 32'({er, ep, ew, ec}));
    wr_n = 1'b1; ctl1_n = 1'b1; ctl2_n = 1'b1;
    settle();
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1: page mode before any latch pulse decodes page 00h
    check(addr == 17'h0005A, "R1", 32'(addr), 32'h5A);
    check({rd_en, psen_rd, wr_en, conflict} == 4'b0, "R1", 32'({rd_en, psen_rd, wr_en, conflict}), 0);

    for (int m = 0; m < 4; m++) begin
      set_mode(2'(m));
      for (int k = 0; k < 16; k++) begin
        a16 = k[0];
        ale_cycle(8'((k * 37 + m * 11 + 3) & 8'hFF));
        adr_fixed = 8'((k * 29 + m) & 8'hFF);
        settle();
        check_addr(m >= 2 ? "R3" : "R2");
        check(addr[16] == a16, "R6", 32'(addr[16]), 32'(a16));
        // R5: shared pins move while ALE low
        ad = 8'(k * 5);
        settle();
        check_addr("R5");
        // R4: page hit, only the dedicated byte changes
        adr_fixed = 8'(adr_fixed + 8'h41);
        settle();
        check_addr("R4");
      end
      if (m == 0 || m == 3) begin
        strobe(1, 0, 1, 1, 0, 0, 0, "R7");
        strobe(1, 1, 0, 1, 1, 0, 0, "R7");
      end else begin
        strobe(1, 0, 1, 1, 1, 0, 0, "R8");
        strobe(1, 1, 0, 0, 0, 0, 0, "R8");
      end
      strobe(0, 1, 1, 0, 0, 1, 0, "R9");
      strobe(0, 0, 1, 0, 0, 0, 1, "R10");
      if (m == 0 || m == 3) strobe(0, 1, 0, 0, 0, 0, 1, "R10");
    end

    // Chip-select boundaries in non-page split mode
    set_mode(2'd0);
    a16 = 1'b0;
    adr_fixed = 8'hFF;
    ale_cycle(8'hF7); settle(); check_addr("R11");
    ale_cycle(8'hF8); settle(); check_addr("R11");
    check(cfg_cs == 1'b1, "R11", 32'(cfg_cs), 1);
    ale_cycle(8'hF9); settle(); check_addr("R11");
    check(cfg_cs == 1'b1, "R11", 32'(cfg_cs), 1);
    ale_cycle(8'hFA); settle(); check_addr("R11");
    a16 = 1'b1;
    ale_cycle(8'hF8); settle(); check_addr("R11");
    check(cfg_cs == 1'b0, "R11", 32'(cfg_cs), 0);
    a16 = 1'b0;
    adr_fixed = 8'h7F;
    ale_cycle(8'hFF); settle(); check_addr("R12");
    check(pri_cs == 1'b1, "R12", 32'(pri_cs), 1);
    adr_fixed = 8'h80;
    ale_cycle(8'h00); settle(); check_addr("R12");
    check(pri_cs == 1'b0, "R12", 32'(pri_cs), 0);

    // R13: mode change while a read is held is deferred
    @(negedge clk);
    ctl1_n = 1'b0;
    settle();
    mode_sel = 2'd1;
    settle();
    check(psen_rd == 1'b0, "R13", 32'(psen_rd), 0);
    check_addr("R13");
    ctl1_n = 1'b1;
    settle();
    cur_mode = 2'd1;
    ctl1_n = 1'b0;
    settle();
    check(psen_rd == 1'b1, "R13", 32'(psen_rd), 1);
    ctl1_n = 1'b1;
    settle();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule